// File: doc/BRIEF.md
# Dual Converter I/O Port Interface

This block sits on an 8-bit, I/O-mapped host bus and lets software run two external analog-to-digital converters through a window of four port addresses. The window lies in the 0x300 region of a 10-bit I/O space. Two switch inputs place it at one of four bases. Each converter owns two ports in the window. The even port starts a conversion when written and returns the conversion result when read. The odd port returns a status byte that carries the converter's busy flag.

Software starts a converter by writing any value to its data/start port. It then polls the status port until the busy bit reads zero, and reads the result from the data/start port. The block turns the end of the write strobe into a one-cycle start pulse. It keeps one busy flag per converter, which the converter's end-of-conversion line clears. During a data-port read it drives the converter's read-enable. A separate output-enable tells the bus glue when the block is driving read data.

Top module: `dual_conv_port`

## Requirements
- R1: A port is selected only when address bits above bit 9 are zero, bits 9 and 8 are one, bits 7 to 4 are zero, and bits 3 and 2 equal the switch value. Addresses such as 0x0200, 0x0100, 0x0700, 0x1300 and 0x0310 select nothing.
- R2: With switch value s, the window base is 0x300 + 4*s. For s = 0, 1, 2 and 3 this gives 0x300, 0x304, 0x308 and 0x30C.
- R3: In the window, offset 0 is the data/start port of converter 0 and offset 2 is the data/start port of converter 1. While the read strobe (active low) is low on one of these ports, rd_data carries that converter's 8-bit result. The result comes from conv_data bits 7:0 for converter 0 and bits 15:8 for converter 1, and conv_rden bit n is high for converter n only.
- R4: Offsets 1 and 3 are the status ports of converters 0 and 1. A read of a status port returns the busy flag in bit 0 and zero in bits 7 to 1. A status read drives no conv_rden bit.
- R5: rd_oe is high only while the read strobe is low and the address selects one of the four ports. Whenever rd_oe is low, rd_data is zero.
- R6: A write strobe (active low) that is sampled low at a rising clock edge on a data/start port makes that converter's conv_start bit high for exactly one cycle. The pulse begins at the first later rising edge where the strobe is sampled high. The address may change once the strobe is high, and at most one start bit is high at a time.
- R7: The busy flag rises at the clock edge that ends the start pulse. It falls at a rising edge where that converter's conv_eoc is high and no start pulse is present. When a start pulse and conv_eoc coincide, the busy flag is set.
- R8: After reset, both busy flags read zero and no conv_start bit is high. A reset asserted during a conversion clears the busy flag.
- R9: A write to a status port, or a write to any address outside the window, produces no start pulse and leaves the busy flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_rd_n | input | 1 | Host read strobe, active low |
| io_wr_n | input | 1 | Host write strobe, active low |
| base_sel | input | 2 | Switch inputs choosing the window base |
| conv_data | input | 16 | Conversion results, converter n in bits 8n+7:8n |
| conv_eoc | input | 2 | End-of-conversion from each converter, active high |
| conv_start | output | 2 | One-cycle start pulse to each converter |
| conv_rden | output | 2 | Read enable to each converter during a data-port read |
| rd_data | output | 8 | Read data toward the host bus |
| rd_oe | output | 1 | High while rd_data is to be driven onto the bus |

## Verification
The assertions assume that both host strobes are already synchronous to clk. They also assume that the two strobes are never low together and that the address does not change while a strobe is low. They further assume that conv_eoc is high only after a conversion has been started. The bench changes every input on the falling clock edge, holds the address steady through each strobe, and asserts conv_eoc only while a converter is busy. In one case it holds conv_eoc high across a start on purpose, to exercise the set-over-clear rule.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  // Each converter occupies a data/start port followed by a status port.
  localparam int unsigned PORTS_PER_CONV = 2;

  // Offset bit 0 tells the two port kinds apart.
  typedef enum logic {
    PORT_DATA   = 1'b0,
    PORT_STATUS = 1'b1
  } port_kind_e;
endpackage

// File: rtl/dcp_decode.sv
module dcp_decode
  import dcp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned NUM_CONV = 2,
  parameter logic [ADDR_W-1:0] REGION_BASE = 16'h0300
) (
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic                io_rd_n,
  input  logic                io_wr_n,
  input  logic [SEL_W-1:0]    base_sel,
  output logic [NUM_CONV-1:0] rd_data_sel,
  output logic [NUM_CONV-1:0] rd_stat_sel,
  output logic [NUM_CONV-1:0] wr_data_sel
);
  localparam int unsigned WIN_W = $clog2(PORTS_PER_CONV * NUM_CONV);
  localparam int unsigned TAG_W = ADDR_W - WIN_W;

  logic [TAG_W-1:0] tag_exp;
  logic             win_hit;
  logic [WIN_W-1:0] offset;

  // The switch value moves the window in steps of one window size.
  assign tag_exp = REGION_BASE[ADDR_W-1:WIN_W] + TAG_W'(base_sel);
  assign win_hit = (io_addr[ADDR_W-1:WIN_W] == tag_exp);
  assign offset  = io_addr[WIN_W-1:0];

  for (genvar i = 0; i < NUM_CONV; i++) begin : g_port
    logic data_hit;
    logic stat_hit;
    assign data_hit = win_hit &&
                      (offset == WIN_W'(PORTS_PER_CONV * i + int'(PORT_DATA)));
    assign stat_hit = win_hit &&
                      (offset == WIN_W'(PORTS_PER_CONV * i + int'(PORT_STATUS)));
    assign rd_data_sel[i] = data_hit && !io_rd_n;
    assign rd_stat_sel[i] = stat_hit && !io_rd_n;
    assign wr_data_sel[i] = data_hit && !io_wr_n;
  end
endmodule

// File: rtl/dcp_start_ctrl.sv
module dcp_start_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_sel,
  input  logic io_wr_n,
  input  logic eoc,
  output logic start,
  output logic busy
);
  logic pend_q, pend_d;
  logic start_q, start_d;
  logic busy_q, busy_d, busy_en;

  always_comb begin
    // Remember a selected write while the strobe is low.
    pend_d  = wr_sel;
    // Pulse once the strobe has gone back high.
    start_d = pend_q && io_wr_n;
    // A start sets the flag and wins over end-of-conversion.
    busy_en = start_q || eoc;
    busy_d  = start_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      start_q <= start_d;
      if (busy_en) begin
        busy_q <= busy_d;
      end
    end
  end

  assign start = start_q;
  assign busy  = busy_q;
endmodule

// File: rtl/dcp_rd_mux.sv
module dcp_rd_mux #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_CONV = 2
) (
  input  logic [NUM_CONV-1:0]        rd_data_sel,
  input  logic [NUM_CONV-1:0]        rd_stat_sel,
  input  logic [NUM_CONV*DATA_W-1:0] conv_data,
  input  logic [NUM_CONV-1:0]        busy,
  output logic [DATA_W-1:0]          rd_data
);
  // Selects are mutually exclusive, so an OR of gated terms suffices.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CONV; i++) begin
      if (rd_data_sel[i]) begin
        rd_data = rd_data | conv_data[i*DATA_W +: DATA_W];
      end
      if (rd_stat_sel[i]) begin
        rd_data = rd_data | {{(DATA_W-1){1'b0}}, busy[i]};
      end
    end
  end
endmodule

// File: rtl/dual_conv_port.sv
module dual_conv_port #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned NUM_CONV = 2,
  parameter logic [ADDR_W-1:0] REGION_BASE = 16'h0300
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           io_addr,
  input  logic                        io_rd_n,
  input  logic                        io_wr_n,
  input  logic [SEL_W-1:0]            base_sel,
  input  logic [NUM_CONV*DATA_W-1:0]  conv_data,
  input  logic [NUM_CONV-1:0]         conv_eoc,
  output logic [NUM_CONV-1:0]         conv_start,
  output logic [NUM_CONV-1:0]         conv_rden,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_oe
);
  logic                rst_meta_q;
  logic                rst_core_n;
  logic [NUM_CONV-1:0] rd_data_sel;
  logic [NUM_CONV-1:0] rd_stat_sel;
  logic [NUM_CONV-1:0] wr_data_sel;
  logic [NUM_CONV-1:0] busy_vec;

  // Reset asserts at once and releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  dcp_decode #(
    .ADDR_W     (ADDR_W),
    .SEL_W      (SEL_W),
    .NUM_CONV   (NUM_CONV),
    .REGION_BASE(REGION_BASE)
  ) u_decode (
    .io_addr    (io_addr),
    .io_rd_n    (io_rd_n),
    .io_wr_n    (io_wr_n),
    .base_sel   (base_sel),
    .rd_data_sel(rd_data_sel),
    .rd_stat_sel(rd_stat_sel),
    .wr_data_sel(wr_data_sel)
  );

  for (genvar i = 0; i < NUM_CONV; i++) begin : g_conv
    dcp_start_ctrl u_start (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .wr_sel (wr_data_sel[i]),
      .io_wr_n(io_wr_n),
      .eoc    (conv_eoc[i]),
      .start  (conv_start[i]),
      .busy   (busy_vec[i])
    );
  end

  dcp_rd_mux #(
    .DATA_W  (DATA_W),
    .NUM_CONV(NUM_CONV)
  ) u_rd_mux (
    .rd_data_sel(rd_data_sel),
    .rd_stat_sel(rd_stat_sel),
    .conv_data  (conv_data),
    .busy       (busy_vec),
    .rd_data    (rd_data)
  );

  assign conv_rden = rd_data_sel;
  assign rd_oe     = |{rd_data_sel, rd_stat_sel};
endmodule

// File: rtl/dcp_chk.sv
module dcp_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_CONV = 2
) (
  input logic                clk,
  input logic                rst_core_n,
  input logic                io_rd_n,
  input logic                io_wr_n,
  input logic [NUM_CONV-1:0] conv_eoc,
  input logic [NUM_CONV-1:0] conv_start,
  input logic [NUM_CONV-1:0] busy_vec,
  input logic [DATA_W-1:0]   rd_data,
  input logic                rd_oe
);
  // R5: no output enable without a read strobe
  a_r5_oe_needs_strobe: assert property (@(posedge clk) disable iff (!rst_core_n)
    io_rd_n |-> !rd_oe);

  // R5: quiet data bus when not enabled
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rd_oe |-> (rd_data == '0));

  // R6: only one converter started at a time
  a_r6_one_start: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(conv_start));

  // R6: a pulse follows a low strobe that has just been released
  a_r6_after_release: assert property (@(posedge clk) disable iff (!rst_core_n)
    (|conv_start) |-> ($past(io_wr_n) && !$past(io_wr_n, 2)));

  for (genvar i = 0; i < NUM_CONV; i++) begin : g_chk
    // R6: single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_core_n)
      conv_start[i] |=> !conv_start[i]);

    // R7: the pulse sets the busy flag, even against end-of-conversion
    a_r7_busy_set: assert property (@(posedge clk) disable iff (!rst_core_n)
      conv_start[i] |=> busy_vec[i]);

    // R7: end-of-conversion clears the flag
    a_r7_busy_clear: assert property (@(posedge clk) disable iff (!rst_core_n)
      (conv_eoc[i] && !conv_start[i]) |=> !busy_vec[i]);

    // R9: without a pulse or end-of-conversion the flag holds
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
      (!conv_start[i] && !conv_eoc[i]) |=> $stable(busy_vec[i]));
  end
endmodule

bind dual_conv_port dcp_chk #(
  .DATA_W  (DATA_W),
  .NUM_CONV(NUM_CONV)
) u_chk (
  .clk       (clk),
  .rst_core_n(rst_core_n),
  .io_rd_n   (io_rd_n),
  .io_wr_n   (io_wr_n),
  .conv_eoc  (conv_eoc),
  .conv_start(conv_start),
  .busy_vec  (busy_vec),
  .rd_data   (rd_data),
  .rd_oe     (rd_oe)
);

// File: tb/sim_dual_conv_port.sv
module sim_dual_conv_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] D0 = 8'hA5;
  localparam logic [7:0] D1 = 8'h3C;
  localparam int NVEC = 16;
  // {addr[15:0], sel[1:0], oe, rden[1:0], data[7:0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {16'h0300, 2'd0, 1'b1, 2'b01, D0},
    {16'h0301, 2'd0, 1'b1, 2'b00, 8'h00},
    {16'h0302, 2'd0, 1'b1, 2'b10, D1},
    {16'h0303, 2'd0, 1'b1, 2'b00, 8'h00},
    {16'h0304, 2'd0, 1'b0, 2'b00, 8'h00},
    {16'h0304, 2'd1, 1'b1, 2'b01, D0},
    {16'h0307, 2'd1, 1'b1, 2'b00, 8'h00},
    {16'h0300, 2'd1, 1'b0, 2'b00, 8'h00},
    {16'h030A, 2'd2, 1'b1, 2'b10, D1},
    {16'h0309, 2'd2, 1'b1, 2'b00, 8'h00},
    {16'h030C, 2'd3, 1'b1, 2'b01, D0},
    {16'h030F, 2'd3, 1'b1, 2'b00, 8'h00},
    {16'h0310, 2'd3, 1'b0, 2'b00, 8'h00},
    {16'h0700, 2'd0, 1'b0, 2'b00, 8'h00},
    {16'h0200, 2'd0, 1'b0, 2'b00, 8'h00},
    {16'h1300, 2'd0, 1'b0, 2'b00, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_rd_n;
  logic        io_wr_n;
  logic [1:0]  base_sel;
  logic [15:0] conv_data;
  logic [1:0]  conv_eoc;
  logic [1:0]  conv_start;
  logic [1:0]  conv_rden;
  logic [7:0]  rd_data;
  logic        rd_oe;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_conv_port u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_rd_n   (io_rd_n),
    .io_wr_n   (io_wr_n),
    .base_sel  (base_sel),
    .conv_data (conv_data),
    .conv_eoc  (conv_eoc),
    .conv_start(conv_start),
    .conv_rden (conv_rden),
    .rd_data   (rd_data),
    .rd_oe     (rd_oe)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Combinational read, sampled 1 time unit after setup; ends on the next falling edge.
  task automatic rd_port(input logic [15:0] a, output logic [7:0] d,
                         output logic oe, output logic [1:0] en);
    io_addr = a;
    io_rd_n = 1'b0;
    #1;
    d  = rd_data;
    oe = rd_oe;
    en = conv_rden;
    io_rd_n = 1'b1;
    @(negedge clk);
  endtask

  // Write strobe low for `hold` edges, then released; returns start samples.
  task automatic wr_port(input logic [15:0] a, input int hold,
                         output logic [1:0] s0, output logic [1:0] s1,
                         output logic [1:0] s2);
    @(negedge clk);
    io_addr = a;
    io_wr_n = 1'b0;
    for (int k = 0; k < hold; k++) @(negedge clk);
    s0 = conv_start;
    io_wr_n = 1'b1;
    io_addr = 16'h0000;
    @(negedge clk);
    s1 = conv_start;
    @(negedge clk);
    s2 = conv_start;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic       oe;
    logic [1:0] en, s0, s1, s2;
    rst_n = 1'b0; io_addr = '0; io_rd_n = 1'b1; io_wr_n = 1'b1;
    base_sel = 2'd0; conv_data = {D1, D0}; conv_eoc = 2'b00;
    do_reset();

    // R8: reset state
    chk("R8 start after reset", 16'(conv_start), 16'h0);
    rd_port(16'h0301, d, oe, en);
    chk("R8 busy0 after reset", 16'(d), 16'h0);
    rd_port(16'h0303, d, oe, en);
    chk("R8 busy1 after reset", 16'(d), 16'h0);

    // R1 R2 R3 R4 R5: decode and read vectors
    for (int v = 0; v < NVEC; v++) begin
      base_sel = VEC[v][12:11];
      rd_port(VEC[v][28:13], d, oe, en);
      chk($sformatf("R1 R2 vec %0d oe", v), 16'(oe), 16'(VEC[v][10]));
      chk($sformatf("R3 R4 R5 vec %0d data", v), 16'(d), 16'(VEC[v][7:0]));
      chk($sformatf("R3 vec %0d rden", v), 16'(en), 16'(VEC[v][9:8]));
    end

    // R6 R7: start converter 0 at base 0x300
    base_sel = 2'd0;
    wr_port(16'h0300, 1, s0, s1, s2);
    chk("R6 no pulse while strobe low", 16'(s0), 16'h0);
    chk("R6 pulse conv0", 16'(s1), 16'h1);
    chk("R6 pulse one cycle", 16'(s2), 16'h0);
    rd_port(16'h0301, d, oe, en);
    chk("R7 busy0 set", 16'(d), 16'h01);
    rd_port(16'h0303, d, oe, en);
    chk("R7 busy1 untouched", 16'(d), 16'h00);
    conv_eoc = 2'b01;
    @(negedge clk);
    conv_eoc = 2'b00;
    rd_port(16'h0301, d, oe, en);
    chk("R7 busy0 cleared by eoc", 16'(d), 16'h00);

    // R6: long strobe, converter 1 at base 0x30C
    base_sel = 2'd3;
    wr_port(16'h030E, 3, s0, s1, s2);
    chk("R6 held strobe no early pulse", 16'(s0), 16'h0);
    chk("R6 pulse conv1", 16'(s1), 16'h2);
    chk("R6 pulse one cycle conv1", 16'(s2), 16'h0);
    rd_port(16'h030F, d, oe, en);
    chk("R7 busy1 set", 16'(d), 16'h01);

    // R9: status port write and out-of-window write
    wr_port(16'h030D, 1, s0, s1, s2);
    chk("R9 status write no pulse", 16'({s1, s2}), 16'h0);
    wr_port(16'h130C, 1, s0, s1, s2);
    chk("R9 upper bit write no pulse", 16'({s1, s2}), 16'h0);
    rd_port(16'h030D, d, oe, en);
    chk("R9 busy0 unchanged", 16'(d), 16'h00);
    rd_port(16'h030F, d, oe, en);
    chk("R9 busy1 unchanged", 16'(d), 16'h01);

    // R7: start coincides with end-of-conversion, set wins
    conv_eoc = 2'b10;
    wr_port(16'h030E, 1, s0, s1, s2);
    chk("R7 pulse under eoc", 16'(s1), 16'h2);
    rd_port(16'h030F, d, oe, en);
    chk("R7 set beats clear", 16'(d), 16'h01);
    rd_port(16'h030F, d, oe, en);
    chk("R7 cleared after pulse", 16'(d), 16'h00);
    conv_eoc = 2'b00;

    // R8: reset during a conversion
    base_sel = 2'd1;
    wr_port(16'h0304, 1, s0, s1, s2);
    rd_port(16'h0305, d, oe, en);
    chk("R8 busy0 before reset", 16'(d), 16'h01);
    do_reset();
    rd_port(16'h0305, d, oe, en);
    chk("R8 busy0 cleared by reset", 16'(d), 16'h00);
    chk("R8 no pulse after reset", 16'(conv_start), 16'h0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule